// File: doc/BRIEF.md
# Two-Wire Bus Master Serial-Clock Generator

This block produces the serial clock of a two-wire bus master from the system clock. Software supplies an 8-bit rate value and a 2-bit scale code. Together they set how many system cycles each clock phase lasts. The block pulls the clock line low through an open-drain style enable. It reads back the real line level, already synchronised by the caller. When another device keeps the line low after release, the block does not count that time as part of the high phase.

The output period starts with a low phase and then moves to a high phase. Each phase lasts `8 + rate * 4^scale` cycles, so an unobstructed period is `16 + 2 * rate * 4^scale` cycles. A downstream shifter uses two one-cycle strobes to move data: one marks the falling edge and one marks the rising edge. Clearing the run input releases the line at once and returns the block to rest. The block is meant for master operation only. A slave-side receiver ignores these settings, and its system clock must run at least 16 times faster than the bus clock. Logic does not enforce that limit.

Top module: `scl_rate_gen`

## Requirements
- R1: With the line unobstructed, the time from one fall strobe to the next equals 16 + 2 * rate * 4^scale system cycles.
- R2: The scale code gives a multiplier of 1 for code 0, 4 for code 1, 16 for code 2 and 64 for code 3.
- R3: In each period, `scl_pull_o` stays high for exactly 8 + rate * 4^scale consecutive cycles. The high phase that follows, from the rise strobe to the next fall strobe, lasts the same number of cycles.
- R4: The high phase advances only in cycles where `scl_in_i` reads 1. If another device holds the line low for S cycles after release, the period grows by exactly S cycles and the rise strobe is delayed by S cycles.
- R5: `fall_stb_o` is high for one cycle: the first cycle of each low phase. `rise_stb_o` is high for one cycle: the first cycle of the high phase in which `scl_in_i` reads 1. The two strobes are never high together.
- R6: When `run_i` is sampled low, `scl_pull_o` is 0 from the next cycle on, no strobe occurs and the phase count restarts. When `run_i` is sampled high from rest, a low phase begins in the next cycle, and `fall_stb_o` marks that cycle.
- R7: A change of rate or scale made during a phase does not alter that phase. It takes effect from the next phase boundary.
- R8: While `rst_n` is low at a clock edge, all outputs are 0 after that edge.
- R9: The largest setting (rate 255, scale 3) gives a period of 32656 cycles without counter overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Enables clock generation when high |
| rate_i | input | 8 | Bit-rate value |
| scale_i | input | 2 | Power-of-four scale code |
| scl_in_i | input | 1 | Synchronised level of the clock line |
| scl_pull_o | output | 1 | 1 drives the clock line low, 0 releases it |
| fall_stb_o | output | 1 | One-cycle strobe in the first cycle of the low phase |
| rise_stb_o | output | 1 | One-cycle strobe in the first counted cycle of the high phase |

## Verification
Run is sampled at an edge, and `fall_stb_o` and `scl_pull_o` answer one cycle later. The rise strobe comes directly from the registered phase and the live line level, so it shows up in the same cycle that the line reads high. The bench drives inputs on falling edges and samples at falling edges. It counts falling edges from one fall strobe to the next event. Each period is then compared with lengths the bench computes from the rate and scale formula. The bench plus the stretch length it applies itself.

// File: rtl/scl_rate_pkg.sv
// Package: shared phase encoding and width helpers for the serial-clock
// generator. Assumes the scale code selects a power of four.
package scl_rate_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Width needed to hold 8 + rate * 4^maxcode with one spare bit.
    function automatic int unsigned cnt_width(input int unsigned rate_w,
                                              input int unsigned scale_w);
        return rate_w + 2 * ((1 << scale_w) - 1) + 1;
    endfunction
endpackage

// File: rtl/scl_half_calc.sv
// Module: scl_half_calc
// Computes the length of one clock phase, 8 + rate * 4^scale, as a
// combinational value. Assumes CNT_W is wide enough for the largest code.
module scl_half_calc #(
    parameter int unsigned RATE_W  = 8,
    parameter int unsigned SCALE_W = 2,
    parameter int unsigned CNT_W   = 15
) (
    input  logic [RATE_W-1:0]  rate_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [CNT_W-1:0]   half_o
);
    localparam int unsigned N_CODES   = 1 << SCALE_W;
    localparam logic [CNT_W-1:0] BASE = CNT_W'(8);

    logic [CNT_W-1:0] scaled [N_CODES];

    // One shifted copy of the rate per scale code.
    for (genvar k = 0; k < N_CODES; k++) begin : g_scale
        assign scaled[k] = CNT_W'(rate_i) << (2 * k);
    end

    // Pick the copy for the current code and add the fixed offset.
    always_comb begin
        half_o = BASE + scaled[scale_i];
    end
endmodule

// File: rtl/scl_phase_ctrl.sv
// Module: scl_phase_ctrl
// Runs the low/high phase sequence. It latches the phase length at each
// phase boundary and counts the high phase only while the line reads high.
// Assumes scl_in_i is already synchronised and half_i >= 8.
module scl_phase_ctrl
    import scl_rate_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             scl_in_i,
    input  logic [CNT_W-1:0] half_i,
    output logic             scl_pull_o,
    output logic             fall_stb_o,
    output logic             rise_stb_o
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic             last_w;

    // Flags the final cycle of the current phase.
    always_comb begin
        last_w = (cnt_q == lim_q - CNT_W'(1));
    end

    // Phase state, counter and latched length.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            lim_q   <= CNT_W'(8);
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                    lim_q   <= half_i;
                end
                PH_LOW: begin
                    if (last_w) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= '0;
                        lim_q   <= half_i;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (scl_in_i) begin
                        if (last_w) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= '0;
                            lim_q   <= half_i;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // Line drive and edge strobes decoded from the phase.
    always_comb begin
        scl_pull_o = (phase_q == PH_LOW);
        fall_stb_o = (phase_q == PH_LOW) && (cnt_q == '0);
        rise_stb_o = (phase_q == PH_HIGH) && (cnt_q == '0) && scl_in_i;
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb_o && rise_stb_o));

    // R5
    fall_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb_o |-> scl_pull_o);

    // R6
    run_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!scl_pull_o && !fall_stb_o && !rise_stb_o));

    // R4
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && phase_q == PH_HIGH && !scl_in_i) |=> $stable(cnt_q));

    // R7
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $stable(lim_q));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < lim_q);
endmodule

// File: rtl/scl_rate_gen.sv
// Module: scl_rate_gen
// Top of the bus-master serial-clock generator: the phase length
// calculator feeds the phase controller. Assumes scl_in_i is synchronised.
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int unsigned RATE_W  = 8,
    parameter int unsigned SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [RATE_W-1:0]  rate_i,
    input  logic [SCALE_W-1:0] scale_i,
    input  logic               scl_in_i,
    output logic               scl_pull_o,
    output logic               fall_stb_o,
    output logic               rise_stb_o
);
    localparam int unsigned CNT_W = cnt_width(RATE_W, SCALE_W);

    logic [CNT_W-1:0] half_w;

    scl_half_calc #(
        .RATE_W (RATE_W),
        .SCALE_W(SCALE_W),
        .CNT_W  (CNT_W)
    ) calc_i (
        .rate_i (rate_i),
        .scale_i(scale_i),
        .half_o (half_w)
    );

    scl_phase_ctrl #(
        .CNT_W(CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run_i),
        .scl_in_i  (scl_in_i),
        .half_i    (half_w),
        .scl_pull_o(scl_pull_o),
        .fall_stb_o(fall_stb_o),
        .rise_stb_o(rise_stb_o)
    );
endmodule

// File: tb/scl_rate_gen_tb.sv
// Bench: sweeps rate/scale settings and measures phase lengths at the ports.
module scl_rate_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       run = 0;
    logic [7:0] rate = 0;
    logic [1:0] scale = 0;
    logic       ext_hold = 0;
    logic       scl_line;
    logic       pull, fall_stb, rise_stb;
    int         n_tests = 0;
    int         n_fail = 0;
    int         cycles = 0;

    assign scl_line = !(pull || ext_hold);

    scl_rate_gen dut_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .rate_i(rate), .scale_i(scale),
        .scl_in_i(scl_line), .scl_pull_o(pull), .fall_stb_o(fall_stb),
        .rise_stb_o(rise_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int half_len(input int r, input int s);
        return 8 + r * (1 << (2 * s));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests = n_tests + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        int guard = 0;
        @(negedge clk);
        while (!fall_stb && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // From a fall strobe: counts cycles to rise and to the next fall.
    task automatic measure(output int t_rise, output int t_fall, output int pull_len);
        int t = 0;
        t_rise = -1;
        pull_len = 0;
        wait_fall();
        while (1) begin
            if (pull) pull_len++;
            @(negedge clk);
            t++;
            if (rise_stb && t_rise < 0) t_rise = t;
            if (fall_stb || t > 70000) break;
        end
        t_fall = t;
    endtask

    initial begin
        int tr, tf, pl, h;
        // R8: reset state
        run = 1;
        repeat (3) @(negedge clk);
        check("R8 pull", int'(pull), 0);
        check("R8 strobes", int'(fall_stb | rise_stb), 0);
        run = 0;
        rst_n = 1;
        @(negedge clk);

        // R6: start from rest gives fall strobe one cycle later
        rate = 0; scale = 0; run = 1;
        @(negedge clk);
        check("R6 start fall", int'(fall_stb), 1);
        check("R6 start pull", int'(pull), 1);

        // R1 R2 R3: sweep of settings, every scale code
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 3; i++) begin
                int r;
                r = (i == 0) ? 0 : ((i == 1) ? 1 : 3 + 2 * s);
                rate = 8'(r); scale = 2'(s);
                wait_fall();  // settings in force from this boundary onward
                measure(tr, tf, pl);
                h = half_len(r, s);
                check("R1 period", tf, 2 * h);
                check("R2 rise time", tr, h);
                check("R3 pull len", pl, h);
            end
        end
        rate = 255; scale = 0;
        wait_fall(); measure(tr, tf, pl);
        check("R1 rate255", tf, 2 * half_len(255, 0));

        // R9: largest setting
        rate = 255; scale = 3;
        wait_fall(); measure(tr, tf, pl);
        check("R9 max period", tf, 32656);
        check("R9 max low", pl, 16328);

        // R4: stretch of S cycles after release
        rate = 4; scale = 0;
        wait_fall();
        for (int S = 1; S <= 7; S += 3) begin
            int t;
            h = half_len(4, 0);
            wait_fall();
            ext_hold = 1;
            t = 0;
            tr = -1;
            while (pull) begin @(negedge clk); t++; end
            repeat (S) begin
                @(negedge clk); t++;
                check("R4 no pull in stretch", int'(pull), 0);
                check("R4 no rise in stretch", int'(rise_stb), 0);
            end
            ext_hold = 0;
            #1;
            if (rise_stb) tr = t;
            while (!fall_stb && t < 1000) begin @(negedge clk); t++; end
            check("R4 rise delay", tr, h + S);
            check("R4 period", t, 2 * h + S);
        end

        // R7: change mid low phase applies from the high phase on
        rate = 10; scale = 0;
        wait_fall(); wait_fall();
        repeat (3) @(negedge clk);
        rate = 20;
        begin
            int t = 3;
            tr = -1;
            while (!fall_stb && t < 1000) begin
                @(negedge clk); t++;
                if (rise_stb && tr < 0) tr = t;
            end
            check("R7 old low", tr, half_len(10, 0));
            check("R7 new high", t - tr, half_len(20, 0));
        end

        // R5: strobe widths, one cycle each
        rate = 2; scale = 0;
        wait_fall();
        @(negedge clk);
        check("R5 fall width", int'(fall_stb), 0);
        while (!rise_stb) @(negedge clk);
        @(negedge clk);
        check("R5 rise width", int'(rise_stb), 0);

        // R6: run low releases, no strobes
        wait_fall();
        @(negedge clk);
        run = 0;
        @(negedge clk);
        check("R6 release", int'(pull), 0);
        begin
            int seen = 0;
            repeat (40) begin
                @(negedge clk);
                if (pull || fall_stb || rise_stb) seen++;
            end
            check("R6 quiet", seen, 0);
        end
        run = 1;
        @(negedge clk);
        check("R6 restart fall", int'(fall_stb), 1);
        measure(tr, tf, pl);
        check("R6 restart period", tf, 2 * half_len(2, 0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule